// File: doc/BRIEF.md
# Hot-Swap Gate Sequencing Controller

This block is the digital core of a hot-swap power controller. It receives comparator decisions that have already been digitised: an overvoltage flag, two undervoltage flags (one for the main supply, a lower one for battery operation), a normal-limit overcurrent flag, an insertion-limit overcurrent flag at three times the normal limit, and a flag that says the external FET gate has reached its fully-on level. It also takes a battery-mode pin, an active-low manual reset pin and a two-bit gate-current select. From these it drives a gate-enable, an 8-bit gate-current value in microamps, an active-low power-good and a sticky failure-after-retry flag.

Every input passes through a two-flop synchronizer. All timing comes from one prescaler that produces a tick every microsecond, derived from the clock-frequency parameter. After reset the gate waits a power-on delay before its first turn-on. An overcurrent only counts once it has persisted for a filter window while the gate is on. A counted overcurrent starts a timed retry loop, and that loop may be bounded by a build parameter. The bounded loop ends in a locked-off state that only manual reset or a fresh reset leaves. All pins are plain level signals; there is no stream interface and no back-pressure.

Top module: `hsc_core`

## Requirements
- R1: After reset, with the voltage inside the window, the gate stays off for POR_US microsecond ticks and is then enabled. At reset gate_en_o=0, pg_n_o=1 and far_o=0.
- R2: An overvoltage, or the selected undervoltage, drops gate_en_o and deasserts power-good in the cycle its synchronized value appears. Once the window is good again, the controller restarts from the full power-on delay. This also applies when the fault arrives during a retry wait: the pending retry is cancelled.
- R3: batt_mode_i=0 selects uv_main_i as the undervoltage condition and ignores uv_batt_i. batt_mode_i=1 selects uv_batt_i and ignores uv_main_i.
- R4: mr_n_i held low for MR_US ticks forces the gate off, clears far_o, restores the insertion limit and restarts from the power-on delay once it rises. A shorter low pulse has no effect.
- R5: From reset or manual reset until power-good first asserts, oc_ins_i is the overcurrent comparator and oc_norm_i is ignored. After that, oc_norm_i is used.
- R6: The selected overcurrent trips the gate only after staying high for FILT_US ticks while the gate is enabled. Shorter spikes leave the gate on.
- R7: After a trip the gate stays off for RETRY_US ticks and is then enabled again. A fault that is still present trips it again.
- R8: With LIMITED=1, once MAX_RETRY consecutive retries have all tripped, the next trip locks the gate off and sets far_o=1 until manual reset or reset. Any power-good in between restarts the count. With LIMITED=0 far_o never rises.
- R9: pg_n_o is low only while the gate is enabled, the window is good, the selected overcurrent flag is low and gate_on_i is high.
- R10: gate_ua_o decodes isel_i as 00->50, 01->10, 10->70, 11->150. It follows the select three clocks after the select changes, at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| ov_i | input | 1 | Overvoltage comparator, 1 = over |
| uv_main_i | input | 1 | Main undervoltage comparator, 1 = under |
| uv_batt_i | input | 1 | Battery undervoltage comparator, 1 = under |
| oc_norm_i | input | 1 | Normal-limit overcurrent comparator |
| oc_ins_i | input | 1 | Insertion-limit overcurrent comparator |
| gate_on_i | input | 1 | Gate above its fully-on level |
| batt_mode_i | input | 1 | 1 = running from battery |
| mr_n_i | input | 1 | Manual reset, active low |
| isel_i | input | 2 | Gate-current select |
| gate_en_o | output | 1 | Gate drive enable |
| gate_ua_o | output | 8 | Selected gate current in microamps |
| pg_n_o | output | 1 | Power-good, active low |
| far_o | output | 1 | Failure after retry, sticky |

## Verification
Two pairs of events can land in the same cycle. The first pair is a manual reset qualifying in the same cycle that an overcurrent qualifies. The bench lowers the manual reset and raises both overcurrent comparators on the same edge, and the two windows are equal, so both filters expire together. Manual reset must win: gate off, far_o clear, restart from the power-on delay. The second pair is an undervoltage arriving just before, on, or just after the retry timer expires. The bench sweeps the pulse position across that edge and compares every output against a behavioural model on every clock. The same comparison runs for a bounded and an unbounded instance fed with identical stimulus.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef enum logic [1:0] {
    ST_POR   = 2'd0,
    ST_RUN   = 2'd1,
    ST_RETRY = 2'd2,
    ST_LOCK  = 2'd3
  } hsc_state_e;

  function automatic logic [7:0] ua_of_code(input logic [1:0] code);
    logic [7:0] r;
    case (code)
      2'b01:   r = 8'd10;
      2'b10:   r = 8'd70;
      2'b11:   r = 8'd150;
      default: r = 8'd50;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/hsc_sync.sv
module hsc_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hsc_tick.sv
module hsc_tick #(
  parameter int DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hsc_persist.sv
module hsc_persist #(
  parameter int LIM = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic lvl,
  output logic hit
);
  localparam int CW = $clog2(LIM + 1);
  localparam logic [CW-1:0] TOP = CW'(LIM);
  logic [CW-1:0] cnt;

  assign hit = lvl && (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (!lvl)                 cnt <= '0;
    else if (tick && (cnt != TOP)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hsc_seq.sv
module hsc_seq
  import hsc_pkg::*;
#(
  parameter int POR_T     = 50000,
  parameter int RETRY_T   = 100000,
  parameter int MAX_RETRY = 5,
  parameter bit LIMITED   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       vok,
  input  logic       mr_hit,
  input  logic       oc_hit,
  input  logic       pg_ok,
  output hsc_state_e st,
  output logic       ins,
  output logic       far
);
  localparam int TMAX = (POR_T > RETRY_T) ? POR_T : RETRY_T;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(MAX_RETRY + 1);
  localparam logic [TW-1:0] POR_END   = TW'(POR_T - 1);
  localparam logic [TW-1:0] RETRY_END = TW'(RETRY_T - 1);
  localparam logic [RW-1:0] RC_MAX    = RW'(MAX_RETRY);

  logic [TW-1:0] tmr;
  logic [RW-1:0] rc;
  logic          lock_now;

  assign lock_now = LIMITED && (rc == RC_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_POR;
      tmr <= '0;
      rc  <= '0;
      ins <= 1'b1;
      far <= 1'b0;
    end else if (mr_hit) begin
      st  <= ST_POR;
      tmr <= '0;
      rc  <= '0;
      ins <= 1'b1;
      far <= 1'b0;
    end else begin
      if (pg_ok) begin
        ins <= 1'b0;
        rc  <= '0;
      end
      if (!vok && (st != ST_LOCK)) begin
        st  <= ST_POR;
        tmr <= '0;
      end else begin
        case (st)
          ST_POR: begin
            if (tick) begin
              if (tmr == POR_END) begin
                st  <= ST_RUN;
                tmr <= '0;
              end else begin
                tmr <= tmr + 1'b1;
              end
            end
          end
          ST_RUN: begin
            if (oc_hit) begin
              tmr <= '0;
              if (lock_now) begin
                st  <= ST_LOCK;
                far <= 1'b1;
              end else begin
                st <= ST_RETRY;
              end
            end
          end
          ST_RETRY: begin
            if (tick) begin
              if (tmr == RETRY_END) begin
                st  <= ST_RUN;
                tmr <= '0;
                rc  <= (rc == RC_MAX) ? rc : rc + 1'b1;
              end else begin
                tmr <= tmr + 1'b1;
              end
            end
          end
          default: st <= ST_LOCK;
        endcase
      end
    end
  end
endmodule

// File: rtl/hsc_core.sv
module hsc_core
  import hsc_pkg::*;
#(
  parameter int CLK_HZ    = 125_000_000,
  parameter int POR_US    = 50_000,
  parameter int RETRY_US  = 100_000,
  parameter int FILT_US   = 5,
  parameter int MR_US     = 5,
  parameter int MAX_RETRY = 5,
  parameter bit LIMITED   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ov_i,
  input  logic       uv_main_i,
  input  logic       uv_batt_i,
  input  logic       oc_norm_i,
  input  logic       oc_ins_i,
  input  logic       gate_on_i,
  input  logic       batt_mode_i,
  input  logic       mr_n_i,
  input  logic [1:0] isel_i,
  output logic       gate_en_o,
  output logic [7:0] gate_ua_o,
  output logic       pg_n_o,
  output logic       far_o
);
  localparam int DIV = CLK_HZ / 1_000_000;
  localparam int NS  = 10;
  localparam logic [NS-1:0] SYNC_RST = 10'b00_0000_0100;

  logic [NS-1:0] raw, syn;
  logic ov_s, uvm_s, uvb_s, ocn_s, oci_s, on_s, batt_s, mr_s;
  logic [1:0] sel_s;
  logic tick, vok, oc_sel, run, oc_hit, mr_hit, pg_ok, ins, far;
  hsc_state_e st;

  assign raw = {ov_i, uv_main_i, uv_batt_i, oc_norm_i, oc_ins_i,
                gate_on_i, batt_mode_i, mr_n_i, isel_i};

  hsc_sync #(.W(NS), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  assign {ov_s, uvm_s, uvb_s, ocn_s, oci_s, on_s, batt_s, mr_s, sel_s} = syn;

  hsc_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  assign vok    = !ov_s && !(batt_s ? uvb_s : uvm_s);
  assign oc_sel = ins ? oci_s : ocn_s;
  assign run    = (st == ST_RUN);

  hsc_persist #(.LIM(FILT_US)) u_oc_filt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lvl(oc_sel && run), .hit(oc_hit)
  );

  hsc_persist #(.LIM(MR_US)) u_mr_filt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lvl(!mr_s), .hit(mr_hit)
  );

  assign pg_ok = run && vok && !oc_sel && on_s && !mr_hit;

  hsc_seq #(
    .POR_T(POR_US), .RETRY_T(RETRY_US), .MAX_RETRY(MAX_RETRY), .LIMITED(LIMITED)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .vok(vok), .mr_hit(mr_hit),
    .oc_hit(oc_hit), .pg_ok(pg_ok), .st(st), .ins(ins), .far(far)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_ua_o <= 8'd50;
    else        gate_ua_o <= ua_of_code(sel_s);
  end

  assign gate_en_o = run && vok && !mr_hit && !oc_hit;
  assign pg_n_o    = !pg_ok;
  assign far_o     = far;
endmodule

// File: rtl/hsc_core_chk.sv
module hsc_core_chk
  import hsc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       gate_en,
  input logic       pg_n,
  input logic       far,
  input logic       vok,
  input logic       mr_hit,
  input logic       ins,
  input hsc_state_e st
);
  p_fault_leaves_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !vok |=> (st != ST_RUN));

  p_mr_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mr_hit |=> ((st == ST_POR) && !far));

  p_ins_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_n |=> !ins);

  p_retry_no_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RETRY) |=> (st != ST_LOCK));

  p_far_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (far && !mr_hit) |=> far);

  p_pg_needs_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_n |-> gate_en);
endmodule

bind hsc_core hsc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gate_en(gate_en_o), .pg_n(pg_n_o), .far(far_o),
  .vok(vok), .mr_hit(mr_hit), .ins(ins), .st(st)
);

// File: tb/test_hsc_core.sv
`timescale 1ns/1ps
module test_hsc_core;
  localparam int CLK_HZ = 4_000_000;
  localparam int DIV    = CLK_HZ / 1_000_000;
  localparam int POR    = 20;
  localparam int RETRY  = 30;
  localparam int FILT   = 5;
  localparam int MRT    = 5;
  localparam int MAXR   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ov = 0, uvm = 0, uvb = 0, ocn = 0, oci = 0, gon = 0, batt = 0, mr_n = 1;
  logic [1:0] sel = 2'b00;
  logic g0, g1, pgn0, pgn1, far0, far1;
  logic [7:0] ua0, ua1;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  hsc_core #(.CLK_HZ(CLK_HZ), .POR_US(POR), .RETRY_US(RETRY), .FILT_US(FILT),
             .MR_US(MRT), .MAX_RETRY(MAXR), .LIMITED(1'b1)) i_hsc_core (
    .clk(clk), .rst_n(rst_n), .ov_i(ov), .uv_main_i(uvm), .uv_batt_i(uvb),
    .oc_norm_i(ocn), .oc_ins_i(oci), .gate_on_i(gon), .batt_mode_i(batt),
    .mr_n_i(mr_n), .isel_i(sel), .gate_en_o(g0), .gate_ua_o(ua0),
    .pg_n_o(pgn0), .far_o(far0));

  hsc_core #(.CLK_HZ(CLK_HZ), .POR_US(POR), .RETRY_US(RETRY), .FILT_US(FILT),
             .MR_US(MRT), .MAX_RETRY(MAXR), .LIMITED(1'b0)) i_hsc_core_nolim (
    .clk(clk), .rst_n(rst_n), .ov_i(ov), .uv_main_i(uvm), .uv_batt_i(uvb),
    .oc_norm_i(ocn), .oc_ins_i(oci), .gate_on_i(gon), .batt_mode_i(batt),
    .mr_n_i(mr_n), .isel_i(sel), .gate_en_o(g1), .gate_ua_o(ua1),
    .pg_n_o(pgn1), .far_o(far1));

  // ---------------- behavioural reference model ----------------
  logic [9:0] p1, p2;
  logic [7:0] m_ua;
  int  mcyc;
  int  m_st [2];
  int  m_tm [2];
  int  m_rc [2];
  int  m_oc [2];
  int  m_mc [2];
  bit  m_ins[2];
  bit  m_far[2];
  bit  m_lim[2];

  function automatic logic [7:0] dec(input logic [1:0] c);
    if (c == 2'b01) return 8'd10;
    if (c == 2'b10) return 8'd70;
    if (c == 2'b11) return 8'd150;
    return 8'd50;
  endfunction

  function automatic bit m_vok();
    return !p2[9] && !(p2[3] ? p2[7] : p2[8]);
  endfunction

  function automatic bit m_osel(int i);
    return m_ins[i] ? p2[5] : p2[6];
  endfunction

  function automatic bit m_mhit(int i);
    return !p2[2] && (m_mc[i] == MRT);
  endfunction

  function automatic bit m_ohit(int i);
    return m_osel(i) && (m_st[i] == 1) && (m_oc[i] == FILT);
  endfunction

  function automatic bit m_pgok(int i);
    return (m_st[i] == 1) && m_vok() && !m_osel(i) && p2[4] && !m_mhit(i);
  endfunction

  function automatic bit m_gate(int i);
    return (m_st[i] == 1) && m_vok() && !m_mhit(i) && !m_ohit(i);
  endfunction

  initial begin
    m_lim[0] = 1'b1;
    m_lim[1] = 1'b0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 = 10'b0000000100;
      p2 = 10'b0000000100;
      m_ua = 8'd50;
      mcyc = 0;
      for (int i = 0; i < 2; i++) begin
        m_st[i] = 0; m_tm[i] = 0; m_rc[i] = 0; m_oc[i] = 0; m_mc[i] = 0;
        m_ins[i] = 1'b1; m_far[i] = 1'b0;
      end
    end else begin
      bit tk;
      tk = ((mcyc % DIV) == DIV - 1);
      for (int i = 0; i < 2; i++) begin
        bit mh, oh, pg, os, vk;
        int nst, ntm, nrc, noc, nmc;
        bit nins, nfar;
        mh = m_mhit(i); oh = m_ohit(i); pg = m_pgok(i); os = m_osel(i); vk = m_vok();
        nst = m_st[i]; ntm = m_tm[i]; nrc = m_rc[i]; nins = m_ins[i]; nfar = m_far[i];
        if (!(os && m_st[i] == 1)) noc = 0;
        else if (tk && m_oc[i] != FILT) noc = m_oc[i] + 1;
        else noc = m_oc[i];
        if (p2[2]) nmc = 0;
        else if (tk && m_mc[i] != MRT) nmc = m_mc[i] + 1;
        else nmc = m_mc[i];
        if (mh) begin
          nst = 0; ntm = 0; nrc = 0; nins = 1; nfar = 0;
        end else begin
          if (pg) begin nins = 0; nrc = 0; end
          if (!vk && m_st[i] != 3) begin
            nst = 0; ntm = 0;
          end else if (m_st[i] == 0) begin
            if (tk) begin
              if (m_tm[i] == POR - 1) begin nst = 1; ntm = 0; end
              else ntm = m_tm[i] + 1;
            end
          end else if (m_st[i] == 1) begin
            if (oh) begin
              ntm = 0;
              if (m_lim[i] && m_rc[i] == MAXR) begin nst = 3; nfar = 1; end
              else nst = 2;
            end
          end else if (m_st[i] == 2) begin
            if (tk) begin
              if (m_tm[i] == RETRY - 1) begin
                nst = 1; ntm = 0;
                nrc = (m_rc[i] == MAXR) ? m_rc[i] : m_rc[i] + 1;
              end else ntm = m_tm[i] + 1;
            end
          end
        end
        m_st[i] = nst; m_tm[i] = ntm; m_rc[i] = nrc; m_oc[i] = noc; m_mc[i] = nmc;
        m_ins[i] = nins; m_far[i] = nfar;
      end
      m_ua = dec(p2[1:0]);
      p2 = p1;
      p1 = {ov, uvm, uvb, ocn, oci, gon, batt, mr_n, sel};
      mcyc = mcyc + 1;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "gate_en (limited)",   int'(g0),   int'(m_gate(0)));
      chk("R2", "gate_en (unlimited)", int'(g1),   int'(m_gate(1)));
      chk("R9", "pg_n (limited)",      int'(pgn0), int'(!m_pgok(0)));
      chk("R9", "pg_n (unlimited)",    int'(pgn1), int'(!m_pgok(1)));
      chk("R8", "far (limited)",       int'(far0), int'(m_far[0]));
      chk("R8", "far (unlimited)",     int'(far1), int'(m_far[1]));
      chk("R10", "gate_ua",            int'(ua0),  int'(m_ua));
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      summary();
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trip_normal();
    ocn = 1'b1;
    wait_cyc(40);
    ocn = 1'b0;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    wait_cyc(3);
    chk("R1", "reset gate_en", int'(g0), 0);
    chk("R1", "reset pg_n", int'(pgn0), 1);
    chk("R1", "reset far", int'(far0), 0);
    rst_n = 1'b1;
    wait_cyc(40);
    chk("R1", "gate held off during power-on delay", int'(g0), 0);
    wait_cyc(60);
    chk("R1", "gate enabled after power-on delay", int'(g0), 1);

    // insertion: normal comparator ignored, insertion comparator active
    ocn = 1'b1;
    wait_cyc(40);
    chk("R5", "normal overcurrent ignored during insertion", int'(g0), 1);
    ocn = 1'b0;
    gon = 1'b1;
    wait_cyc(6);
    chk("R9", "power-good asserted", int'(pgn0), 0);

    // current select decode
    for (int c = 0; c < 4; c++) begin
      sel = c[1:0];
      wait_cyc(4);
      chk("R10", "gate current decode", int'(ua0), int'(dec(c[1:0])));
    end
    sel = 2'b00;

    // short spike ignored
    ocn = 1'b1;
    wait_cyc(12);
    ocn = 1'b0;
    wait_cyc(4);
    chk("R6", "short overcurrent spike ignored", int'(g0), 1);

    // real trip and retry
    trip_normal();
    chk("R6", "persistent overcurrent trips gate", int'(g0), 0);
    wait_cyc(130);
    chk("R7", "gate re-enabled after retry wait", int'(g0), 1);
    wait_cyc(10);

    // battery selection
    uvb = 1'b1;
    wait_cyc(30);
    chk("R3", "battery undervoltage ignored in main mode", int'(g0), 1);
    batt = 1'b1;
    wait_cyc(8);
    chk("R3", "battery undervoltage selected in battery mode", int'(g0), 0);
    uvb = 1'b0;
    uvm = 1'b1;
    wait_cyc(100);
    chk("R3", "main undervoltage ignored in battery mode", int'(g0), 1);
    batt = 1'b0;
    wait_cyc(8);
    chk("R2", "main undervoltage turns gate off", int'(g0), 0);
    chk("R2", "main undervoltage drops power-good", int'(pgn0), 1);
    uvm = 1'b0;
    wait_cyc(40);
    chk("R2", "power-on delay restarts after undervoltage", int'(g0), 0);
    wait_cyc(60);
    chk("R2", "gate back after restarted delay", int'(g0), 1);
    ov = 1'b1;
    wait_cyc(4);
    chk("R2", "overvoltage turns gate off", int'(g0), 0);
    ov = 1'b0;
    wait_cyc(110);

    // undervoltage during retry cancels the retry
    trip_normal();
    uvm = 1'b1;
    wait_cyc(120);
    uvm = 1'b0;
    wait_cyc(10);
    chk("R2", "retry cancelled by undervoltage", int'(g0), 0);
    wait_cyc(100);
    chk("R2", "gate back after delay following cancelled retry", int'(g0), 1);

    // sweep an undervoltage pulse across the retry expiry
    for (int off = 96; off <= 132; off += 3) begin
      trip_normal();
      wait_cyc(off);
      uvm = 1'b1;
      wait_cyc(4);
      uvm = 1'b0;
      wait_cyc(260);
    end

    // hard short: bounded instance locks, unbounded keeps retrying
    gon = 1'b0;
    ocn = 1'b1;
    wait_cyc(1500);
    chk("R8", "bounded retry locks with failure flag", int'(far0), 1);
    chk("R8", "unbounded retry never sets failure flag", int'(far1), 0);
    chk("R8", "locked gate stays off", int'(g0), 0);
    ocn = 1'b0;

    // short manual reset ignored, long one clears
    mr_n = 1'b0;
    wait_cyc(8);
    mr_n = 1'b1;
    wait_cyc(10);
    chk("R4", "short manual reset pulse ignored", int'(far0), 1);
    mr_n = 1'b0;
    wait_cyc(40);
    chk("R4", "manual reset clears failure flag", int'(far0), 0);
    chk("R4", "manual reset holds gate off", int'(g0), 0);
    mr_n = 1'b1;
    wait_cyc(40);
    chk("R4", "power-on delay after manual reset", int'(g0), 0);
    wait_cyc(60);
    chk("R4", "gate on after manual reset release", int'(g0), 1);

    // insertion limit restored by manual reset: insertion comparator trips
    oci = 1'b1;
    wait_cyc(40);
    chk("R5", "insertion comparator active after manual reset", int'(g0), 0);
    oci = 1'b0;
    wait_cyc(130);
    gon = 1'b1;
    wait_cyc(10);

    // manual reset and overcurrent qualifying in the same cycle
    mr_n = 1'b0;
    ocn = 1'b1;
    oci = 1'b1;
    wait_cyc(40);
    chk("R4", "manual reset wins over simultaneous overcurrent", int'(g0), 0);
    chk("R4", "no failure flag from simultaneous event", int'(far0), 0);
    ocn = 1'b0;
    oci = 1'b0;
    mr_n = 1'b1;
    wait_cyc(120);
    chk("R4", "restart after simultaneous event", int'(g0), 1);
    wait_cyc(20);
    summary();
  end
endmodule